// File: doc/BRIEF.md
# Virtual-Channel Ejection Reassembler

This block sits at the output port of a network node. Flits that leave the network land in a small ejection FIFO belonging to their virtual channel (VC). Each cycle, every VC whose ejection FIFO holds a flit and whose boundary buffer has a free slot moves one flit across. That move returns a credit to the upstream router for the same VC.

The boundary buffer keeps a count of the complete packets it holds. A packet counts as complete once its tail flit has arrived. The consumer raises a pop request to take one whole packet. A round-robin picker chooses the VC. The block drops the packet's flits and hands back the payload carried by its tail flit, one cycle after the request.

The block also reports two errors. The first is a flit that arrives at a full ejection FIFO. The second is a head flit whose destination field is not this node.

Top module: `vc_eject_reasm`

## Requirements
- R1: In each cycle, VC v moves exactly one flit from its ejection FIFO to its boundary buffer when the ejection FIFO is non-empty and the boundary buffer holds fewer than BND_DEPTH flits. Otherwise VC v moves no flit.
- R2: `credit[v]` (bit v belongs to VC v) is high for exactly the cycles in which VC v moves a flit, one pulse per moved flit.
- R3: A VC's packet count rises when a flit with `in_tail`=1 enters its boundary buffer. `busy` is high exactly when at least one VC holds a complete packet.
- R4: A pop request sampled while some VC holds a complete packet produces `pkt_valid`=1 on the next cycle. In that cycle `pkt_data` is the payload of that VC's oldest tail flit. The pop removes every flit of that VC up to and including that tail.
- R5: The VC search starts at a saved pointer (0 after reset) and visits each VC once in increasing index order, wrapping around. The first VC with a complete packet is served, `pkt_vc` reports its index, and the pointer becomes that index plus one, modulo NUM_VC.
- R6: A pop request sampled while no VC holds a complete packet gives `pkt_valid`=0 on the next cycle, removes nothing and leaves the pointer unchanged.
- R7: A flit offered (`in_valid`=1) to a VC whose ejection FIFO already holds EJ_DEPTH flits is discarded. `err_overflow` is high for the following cycle. EJ_DEPTH defaults to VC_DEPTH.
- R8: A flit with `in_head`=1 and `in_dest` different from NODE_ID raises `err_dest` for the following cycle, and the flit is still stored. The `in_dest` value of a non-head flit is ignored.
- R9: After synchronous reset, all buffers are empty, the pointer is 0, and `credit`, `busy`, `pkt_valid`, `err_overflow` and `err_dest` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Ejected flit present |
| in_data | input | DATA_W | Flit payload |
| in_vc | input | $clog2(NUM_VC) | Binary VC index of the flit |
| in_head | input | 1 | Flit is the first of its packet |
| in_tail | input | 1 | Flit is the last of its packet |
| in_dest | input | NODE_W | Destination node field (checked on head flits) |
| credit | output | NUM_VC | Per-VC credit pulse, bit v for VC v |
| pop_req | input | 1 | Request to deliver one packet |
| pkt_valid | output | 1 | Packet delivered this cycle |
| pkt_data | output | DATA_W | Tail payload of the delivered packet |
| pkt_vc | output | $clog2(NUM_VC) | VC of the delivered packet |
| busy | output | 1 | Some VC holds a complete packet |
| err_overflow | output | 1 | A flit was discarded at a full ejection FIFO |
| err_dest | output | 1 | A head flit carried a foreign destination |

## Verification
The critical overlap is a pop on a VC in the same cycle that VC moves a flit into its boundary buffer, possibly a tail. The pop must take only packets already complete before the edge, and the new flit must land behind them. A second overlap is a flit offered to an ejection FIFO that is full while a transfer drains it in the same cycle; it must still be rejected. The stimulus provokes both by holding pops off until the boundary buffers fill and overflows begin, then mixing random pops with dense random traffic. A behavioural queue model predicts credits, busy, deliveries and error pulses, and these are compared every cycle.

// File: rtl/ejr_pkg.sv
package ejr_pkg;
  // Modular increment used by the round-robin search.
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/ejr_eject_fifo.sv
module ejr_eject_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty   = (wp == rp);
  assign full    = ((wp - rp) == FULL_CNT);
  assign rd_data = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en && !full) wp <= wp + 1'b1;
      if (rd_en)          rp <= rp + 1'b1;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R2
endmodule

// File: rtl/ejr_bnd_buf.sv
module ejr_bnd_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_tail,
  input  logic          pop,
  output logic          space,
  output logic          has_pkt,
  output logic [DW-1:0] tail_data
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [DW-1:0] mem  [DEPTH];
  logic [AW:0]   tidx [DEPTH];
  logic [AW:0]   wp, rp, twp, trp, pcnt, occ, tail_ptr;
  logic          add_pkt;

  assign add_pkt   = wr_en && wr_tail;
  assign occ       = wp - rp;
  assign space     = (occ < FULL_CNT);
  assign has_pkt   = (pcnt != '0);
  assign tail_ptr  = tidx[trp[AW-1:0]];
  assign tail_data = mem[tail_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en)   mem[wp[AW-1:0]]   <= wr_data;
    if (add_pkt) tidx[twp[AW-1:0]] <= wp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      twp  <= '0;
      trp  <= '0;
      pcnt <= '0;
    end else begin
      if (wr_en)   wp  <= wp + 1'b1;
      if (add_pkt) twp <= twp + 1'b1;
      if (pop) begin
        rp  <= tail_ptr + 1'b1;
        trp <= trp + 1'b1;
      end
      pcnt <= pcnt + {{AW{1'b0}}, add_pkt} - {{AW{1'b0}}, pop};
    end
  end

  AST_BND_ROOM:    assert property (@(posedge clk) disable iff (rst) wr_en |-> (occ < FULL_CNT)); // R1
  AST_POP_HAS_PKT: assert property (@(posedge clk) disable iff (rst) pop |-> (pcnt != '0));        // R4
endmodule

// File: rtl/ejr_rr_pick.sv
module ejr_rr_pick
  import ejr_pkg::*;
#(
  parameter int N   = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  avail,
  input  logic          pop_req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          found
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    found     = 1'b0;
    grant_idx = ptr_q;
    grant     = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && avail[IW'(wrap_add(int'(ptr_q), i, N))]) begin
        found     = 1'b1;
        grant_idx = IW'(wrap_add(int'(ptr_q), i, N));
      end
    end
    if (pop_req && found) grant[grant_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (pop_req && found) ptr_q <= IW'(wrap_add(int'(grant_idx), 1, N));
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst) !(pop_req && found) |=> $stable(ptr_q)); // R6
  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (rst) (pop_req && |avail) |-> $onehot(grant)); // R5
endmodule

// File: rtl/vc_eject_reasm.sv
module vc_eject_reasm #(
  parameter int NUM_VC    = 4,
  parameter int DATA_W    = 16,
  parameter int NODE_W    = 4,
  parameter int NODE_ID   = 5,
  parameter int VC_DEPTH  = 4,
  parameter int EJ_DEPTH  = VC_DEPTH,
  parameter int BND_DEPTH = 8,
  localparam int VCW      = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [VCW-1:0]    in_vc,
  input  logic              in_head,
  input  logic              in_tail,
  input  logic [NODE_W-1:0] in_dest,
  output logic [NUM_VC-1:0] credit,
  input  logic              pop_req,
  output logic              pkt_valid,
  output logic [DATA_W-1:0] pkt_data,
  output logic [VCW-1:0]    pkt_vc,
  output logic              busy,
  output logic              err_overflow,
  output logic              err_dest
);
  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);

  logic [NUM_VC-1:0] ej_full, ej_empty, xfer, bnd_space, bnd_has, grant;
  logic [DATA_W:0]   ej_out    [NUM_VC];
  logic [DATA_W-1:0] tail_data [NUM_VC];
  logic [VCW-1:0]    gidx;
  logic              found;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic wr_here;
    assign wr_here = in_valid && (in_vc == VCW'(v));
    assign xfer[v] = !ej_empty[v] && bnd_space[v];

    ejr_eject_fifo #(.W(DATA_W + 1), .DEPTH(EJ_DEPTH)) u_ej (
      .clk(clk), .rst(rst),
      .wr_en(wr_here), .wr_data({in_tail, in_data}),
      .rd_en(xfer[v]), .rd_data(ej_out[v]),
      .empty(ej_empty[v]), .full(ej_full[v])
    );

    ejr_bnd_buf #(.DW(DATA_W), .DEPTH(BND_DEPTH)) u_bnd (
      .clk(clk), .rst(rst),
      .wr_en(xfer[v]), .wr_data(ej_out[v][DATA_W-1:0]), .wr_tail(ej_out[v][DATA_W]),
      .pop(grant[v]),
      .space(bnd_space[v]), .has_pkt(bnd_has[v]), .tail_data(tail_data[v])
    );
  end

  ejr_rr_pick #(.N(NUM_VC)) u_rr (
    .clk(clk), .rst(rst), .avail(bnd_has), .pop_req(pop_req),
    .grant(grant), .grant_idx(gidx), .found(found)
  );

  assign credit = xfer;
  assign busy   = |bnd_has;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid    <= 1'b0;
      pkt_data     <= '0;
      pkt_vc       <= '0;
      err_overflow <= 1'b0;
      err_dest     <= 1'b0;
    end else begin
      pkt_valid <= pop_req && found;
      if (pop_req && found) begin
        pkt_data <= tail_data[gidx];
        pkt_vc   <= gidx;
      end
      err_overflow <= in_valid && ej_full[in_vc];
      err_dest     <= in_valid && in_head && (in_dest != MY_ID);
    end
  end

  AST_POP_SERVES: assert property (@(posedge clk) disable iff (rst) (pop_req && busy) |=> pkt_valid);   // R4
  AST_IDLE_POP:   assert property (@(posedge clk) disable iff (rst) (pop_req && !busy) |=> !pkt_valid); // R6
endmodule

// File: tb/vc_eject_reasm_bench.sv
module vc_eject_reasm_bench;
  localparam int NV = 4, DW = 16, NW = 4, NID = 5, EJD = 4, BD = 8, VW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_head = 0, in_tail = 0, pop_req = 0;
  logic [DW-1:0] in_data = '0;
  logic [VW-1:0] in_vc = '0;
  logic [NW-1:0] in_dest = '0;
  logic [NV-1:0] credit;
  logic pkt_valid, busy, err_overflow, err_dest;
  logic [DW-1:0] pkt_data;
  logic [VW-1:0] pkt_vc;

  always #4 clk = ~clk;

  vc_eject_reasm #(.NUM_VC(NV), .DATA_W(DW), .NODE_W(NW), .NODE_ID(NID),
                   .VC_DEPTH(EJD), .BND_DEPTH(BD)) u_vc_eject_reasm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_vc(in_vc),
    .in_head(in_head), .in_tail(in_tail), .in_dest(in_dest), .credit(credit),
    .pop_req(pop_req), .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_vc(pkt_vc),
    .busy(busy), .err_overflow(err_overflow), .err_dest(err_dest));

  // Behavioural reference state
  logic [DW:0] ejq [NV][$];
  logic [DW:0] bq  [NV][$];
  int pcnt [NV];
  int rr;
  logic exp_pv, exp_ovf, exp_dst;
  logic [DW-1:0] exp_pd;
  logic [VW-1:0] exp_pvc;
  int checks = 0, errors = 0;
  int rem [NV];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic model_step();
    bit mv [NV];
    int szp [NV];
    bit got;
    logic [DW:0] f;
    for (int v = 0; v < NV; v++) begin
      mv[v]  = (ejq[v].size() > 0) && (bq[v].size() < BD);
      szp[v] = ejq[v].size();
    end
    exp_pv = 1'b0;
    got = 1'b0;
    if (pop_req) begin
      for (int i = 0; i < NV; i++) begin
        int v;
        v = (rr + i) % NV;
        if (!got && pcnt[v] > 0) begin
          got = 1'b1;
          exp_pv = 1'b1;
          exp_pvc = VW'(v);
          do f = bq[v].pop_front(); while (!f[DW]);
          exp_pd = f[DW-1:0];
          pcnt[v]--;
          rr = (v + 1) % NV;
        end
      end
    end
    for (int v = 0; v < NV; v++) begin
      if (mv[v]) begin
        f = ejq[v].pop_front();
        bq[v].push_back(f);
        if (f[DW]) pcnt[v]++;
      end
    end
    exp_ovf = 1'b0;
    exp_dst = 1'b0;
    if (in_valid) begin
      if (szp[in_vc] == EJD) exp_ovf = 1'b1;
      else ejq[in_vc].push_back({in_tail, in_data});
      if (in_head && in_dest != NW'(NID)) exp_dst = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < NV; v++) begin
        ejq[v].delete();
        bq[v].delete();
        pcnt[v] = 0;
      end
      rr = 0;
      exp_pv = 0; exp_ovf = 0; exp_dst = 0; exp_pd = '0; exp_pvc = '0;
    end else begin
      model_step();
    end
  end

  task automatic check_outputs();
    logic [NV-1:0] ec;
    bit eb;
    eb = 1'b0;
    for (int v = 0; v < NV; v++) begin
      ec[v] = (ejq[v].size() > 0) && (bq[v].size() < BD);
      if (pcnt[v] > 0) eb = 1'b1;
    end
    chk(credit == ec, "R1 R2 credit", 32'(credit), 32'(ec));
    chk(busy == eb, "R3 busy", 32'(busy), 32'(eb));
    chk(pkt_valid == exp_pv, exp_pv ? "R4 pkt_valid" : "R6 pkt_valid", 32'(pkt_valid), 32'(exp_pv));
    if (exp_pv && pkt_valid) begin
      chk(pkt_data == exp_pd, "R4 pkt_data", 32'(pkt_data), 32'(exp_pd));
      chk(pkt_vc == exp_pvc, "R5 pkt_vc", 32'(pkt_vc), 32'(exp_pvc));
    end
    chk(err_overflow == exp_ovf, "R7 err_overflow", 32'(err_overflow), 32'(exp_ovf));
    chk(err_dest == exp_dst, "R8 err_dest", 32'(err_dest), 32'(exp_dst));
  endtask

  task automatic drive(input int cyc);
    int pin, ppop, v;
    if (cyc < 80)        begin pin = 90; ppop = 0;  end
    else if (cyc < 3000) begin pin = 60; ppop = 50; end
    else                 begin pin = 0;  ppop = 70; end
    pop_req  = ($urandom_range(0, 99) < ppop);
    in_valid = ($urandom_range(0, 99) < pin);
    if (in_valid) begin
      v = $urandom_range(0, NV - 1);
      in_vc   = VW'(v);
      in_head = (rem[v] == 0);
      if (rem[v] == 0) rem[v] = $urandom_range(1, 3);
      in_tail = (rem[v] == 1);
      rem[v]--;
      in_data = DW'($urandom);
      if (in_head) in_dest = ($urandom_range(0, 15) == 0) ? NW'(NID ^ 1) : NW'(NID);
      else         in_dest = NW'($urandom); // R8: ignored on non-head flits
    end else begin
      in_head = 1'b0;
      in_tail = 1'b0;
    end
  endtask

  initial begin
    for (int v = 0; v < NV; v++) rem[v] = 0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(credit == '0, "R9 credit", 32'(credit), 0);
    chk(busy == 1'b0, "R9 busy", 32'(busy), 0);
    chk(pkt_valid == 1'b0, "R9 pkt_valid", 32'(pkt_valid), 0);
    chk(err_overflow == 1'b0 && err_dest == 1'b0, "R9 errors", {30'd0, err_overflow, err_dest}, 0);
    rst = 1'b0;
    for (int cyc = 0; cyc < 3500; cyc++) begin
      @(negedge clk);
      check_outputs();
      drive(cyc);
    end
    @(negedge clk);
    check_outputs();
    chk(busy == 1'b0, "R3 drained busy", 32'(busy), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule